// File: doc/BRIEF.md
# Lane Width Negotiation Sequencer

This sequencer settles, after every reset or restart request, how many data lanes a serial link uses in each direction. It first sits out a fixed legacy configuration window. Then it advertises its own maximum transmit and receive lane counts and watches what the peer sends back. A capability reply marks a newer-generation peer and carries that peer's own maxima. Error symbols in the reply mark a legacy peer that did not understand the message. In that case the number of lanes carrying error symbols is taken as that peer's usable width in both directions.

The agreed width in each direction is the smaller of the local maximum and the peer's figure, so transmit and receive widths can differ. If no answer arrives within a timeout, the sequencer falls back to one lane each way. The outputs are the two width codes, a status word holding a link-up flag and the peer-generation flag, and a one-cycle done strobe. Lane serialization itself lives elsewhere.

Top module: `lane_width_negotiator`

## Requirements
- R1: While reset is held, and right after its release, both width outputs read code 00, done_o and adv_valid_o are low and the status word is zero.
- R2: After reset release, or after a cycle with reinit_i high, adv_valid_o stays low for exactly LEGACY_CYCLES cycles and then rises. While it is high, adv_tx_code_o and adv_rx_code_o equal the local maximum codes.
- R3: Every width code uses the mapping 00 = 1 lane, 01 = 2 lanes, 11 = 3 lanes, 10 = 4 lanes.
- R4: A capability reply (peer_cap_valid_i high while advertising) sets the TX width to min(local TX max, peer RX max) and the RX width to min(local RX max, peer TX max). It also sets the peer-generation bit to 1.
- R5: An error reply (peer_err_valid_i high while advertising, with at least one bit of peer_err_lanes_i set) takes N, the count of set bits, as the peer width. The TX width becomes min(local TX max, N), the RX width becomes min(local RX max, N), and the peer-generation bit becomes 0.
- R6: A capability reply wins over an error reply in the same cycle. An error reply with no lane bit set is ignored and advertising continues.
- R7: If no accepted reply arrives within REPLY_TIMEOUT cycles of adv_valid_o rising, both widths become code 00, the peer-generation bit becomes 0 and done_o fires.
- R8: done_o is high for exactly one cycle, one cycle after the accepted reply or the timeout edge. The new widths are visible in that cycle, and adv_valid_o falls in that same cycle.
- R9: After done, the width outputs and status hold steady, and reply inputs have no effect, until reinit_i or reset. Reply inputs during the legacy window are also ignored.
- R10: reinit_i clears the widths to 00 and clears the status, then restarts the legacy window.
- R11: neg_status_o bit 0 is the link-up flag (set at done) and bit 16 is the peer generation (0 legacy, 1 newer). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reinit_i | input | 1 | Restart negotiation from the legacy window |
| local_tx_max_i | input | 2 | Local maximum TX width code |
| local_rx_max_i | input | 2 | Local maximum RX width code |
| adv_valid_o | output | 1 | Capability advertisement active |
| adv_tx_code_o | output | 2 | Advertised TX maximum code |
| adv_rx_code_o | output | 2 | Advertised RX maximum code |
| peer_cap_valid_i | input | 1 | Peer capability reply seen this cycle |
| peer_tx_max_i | input | 2 | Peer maximum TX width code |
| peer_rx_max_i | input | 2 | Peer maximum RX width code |
| peer_err_valid_i | input | 1 | Error symbols seen this cycle |
| peer_err_lanes_i | input | NUM_LANES | Lanes carrying error symbols |
| tx_width_o | output | 2 | Agreed TX width code |
| rx_width_o | output | 2 | Agreed RX width code |
| neg_status_o | output | 32 | Status: bit 0 link up, bit 16 peer generation |
| done_o | output | 1 | One-cycle negotiation complete strobe |

## Verification
The bench counts the legacy window to the exact cycle after both reset and restart, so an off-by-one counter shows up as a wrong count. It sends asymmetric capability replies, and a design that swapped the peer's TX and RX figures, or that took max instead of min, would end with the wrong width code. It sends an error reply alongside a capability reply, an empty error mask, and stray replies during the legacy window and after done. A design with the wrong priority, or one that counted zero lanes, would either finish early or latch the wrong widths. The silent-peer case measures the timeout length and checks the single-lane fallback.

// File: rtl/lwn_pkg.sv
package lwn_pkg;
  typedef enum logic [1:0] {ST_LEGACY, ST_ADVERT, ST_DONE, ST_HOLD} lwn_state_e;

  function automatic logic [2:0] code_to_lanes(input logic [1:0] c);
    case (c)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b11:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] lanes_to_code(input logic [2:0] n);
    case (n)
      3'd2:    return 2'b01;
      3'd3:    return 2'b11;
      3'd4:    return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] min_code(input logic [1:0] a, input logic [1:0] b);
    return (code_to_lanes(a) <= code_to_lanes(b)) ? a : b;
  endfunction
endpackage

// File: rtl/lwn_timer.sv
module lwn_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_expire_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clear_i) |=> (cnt_q == LAST));
endmodule

// File: rtl/lwn_lane_count.sv
module lwn_lane_count #(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0] lanes_i,
  output logic [2:0]           lanes_o
);
  localparam int CNT_W = $clog2(NUM_LANES + 1);

  logic [CNT_W-1:0] psum [NUM_LANES+1];
  assign psum[0] = '0;

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_sum
    assign psum[gi+1] = psum[gi] + CNT_W'(lanes_i[gi]);
  end

  assign lanes_o = 3'(psum[NUM_LANES]);

  always_comb begin
    a_count_r5: assert ($countones(lanes_i) == int'(lanes_o));
  end
endmodule

// File: rtl/lwn_width_resolve.sv
module lwn_width_resolve #(
  parameter int NUM_LANES = 4
) (
  input  logic [1:0]           local_tx_i,
  input  logic [1:0]           local_rx_i,
  input  logic [1:0]           peer_tx_i,
  input  logic [1:0]           peer_rx_i,
  input  logic [NUM_LANES-1:0] err_lanes_i,
  output logic [1:0]           cap_tx_o,
  output logic [1:0]           cap_rx_o,
  output logic [1:0]           err_tx_o,
  output logic [1:0]           err_rx_o,
  output logic                 err_seen_o
);
  import lwn_pkg::*;

  logic [2:0] err_n;
  logic [1:0] err_code;

  lwn_lane_count #(.NUM_LANES(NUM_LANES)) u_cnt (
    .lanes_i (err_lanes_i),
    .lanes_o (err_n)
  );

  assign err_seen_o = (err_n != 3'd0);
  assign err_code   = lanes_to_code(err_n);

  // peer RX capability bounds our TX and vice versa
  assign cap_tx_o = min_code(local_tx_i, peer_rx_i);
  assign cap_rx_o = min_code(local_rx_i, peer_tx_i);
  assign err_tx_o = min_code(local_tx_i, err_code);
  assign err_rx_o = min_code(local_rx_i, err_code);
endmodule

// File: rtl/lane_width_negotiator.sv
module lane_width_negotiator #(
  parameter int NUM_LANES     = 4,
  parameter int LEGACY_CYCLES = 2000,
  parameter int REPLY_TIMEOUT = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reinit_i,
  input  logic [1:0]           local_tx_max_i,
  input  logic [1:0]           local_rx_max_i,
  output logic                 adv_valid_o,
  output logic [1:0]           adv_tx_code_o,
  output logic [1:0]           adv_rx_code_o,
  input  logic                 peer_cap_valid_i,
  input  logic [1:0]           peer_tx_max_i,
  input  logic [1:0]           peer_rx_max_i,
  input  logic                 peer_err_valid_i,
  input  logic [NUM_LANES-1:0] peer_err_lanes_i,
  output logic [1:0]           tx_width_o,
  output logic [1:0]           rx_width_o,
  output logic [31:0]          neg_status_o,
  output logic                 done_o
);
  import lwn_pkg::*;

  lwn_state_e state_q;
  logic [1:0] tx_q, rx_q;
  logic       gen_q, link_q;
  logic       leg_exp, rep_exp;
  logic [1:0] cap_tx, cap_rx, err_tx, err_rx;
  logic       err_seen;

  lwn_timer #(.LIMIT(LEGACY_CYCLES)) u_legacy_tmr (
    .clk_i, .rst_ni,
    .clear_i   (reinit_i || state_q != ST_LEGACY),
    .run_i     (state_q == ST_LEGACY),
    .expired_o (leg_exp)
  );

  lwn_timer #(.LIMIT(REPLY_TIMEOUT)) u_reply_tmr (
    .clk_i, .rst_ni,
    .clear_i   (reinit_i || state_q != ST_ADVERT),
    .run_i     (state_q == ST_ADVERT),
    .expired_o (rep_exp)
  );

  lwn_width_resolve #(.NUM_LANES(NUM_LANES)) u_resolve (
    .local_tx_i  (local_tx_max_i),
    .local_rx_i  (local_rx_max_i),
    .peer_tx_i   (peer_tx_max_i),
    .peer_rx_i   (peer_rx_max_i),
    .err_lanes_i (peer_err_lanes_i),
    .cap_tx_o    (cap_tx),
    .cap_rx_o    (cap_rx),
    .err_tx_o    (err_tx),
    .err_rx_o    (err_rx),
    .err_seen_o  (err_seen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LEGACY;
      tx_q    <= 2'b00;
      rx_q    <= 2'b00;
      gen_q   <= 1'b0;
      link_q  <= 1'b0;
    end else if (reinit_i) begin
      state_q <= ST_LEGACY;
      tx_q    <= 2'b00;
      rx_q    <= 2'b00;
      gen_q   <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_LEGACY: if (leg_exp) state_q <= ST_ADVERT;
        ST_ADVERT: begin
          if (peer_cap_valid_i) begin
            tx_q <= cap_tx; rx_q <= cap_rx;
            gen_q <= 1'b1; link_q <= 1'b1; state_q <= ST_DONE;
          end else if (peer_err_valid_i && err_seen) begin
            tx_q <= err_tx; rx_q <= err_rx;
            gen_q <= 1'b0; link_q <= 1'b1; state_q <= ST_DONE;
          end else if (rep_exp) begin
            tx_q <= 2'b00; rx_q <= 2'b00;
            gen_q <= 1'b0; link_q <= 1'b1; state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_HOLD;
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign adv_valid_o   = (state_q == ST_ADVERT);
  assign adv_tx_code_o = local_tx_max_i;
  assign adv_rx_code_o = local_rx_max_i;
  assign done_o        = (state_q == ST_DONE);
  assign tx_width_o    = tx_q;
  assign rx_width_o    = rx_q;
  assign neg_status_o  = {15'b0, gen_q, 15'b0, link_q};

  logic [2:0] tx_lanes, rx_lanes, loc_tx_lanes, loc_rx_lanes;
  assign tx_lanes     = code_to_lanes(tx_q);
  assign rx_lanes     = code_to_lanes(rx_q);
  assign loc_tx_lanes = code_to_lanes(local_tx_max_i);
  assign loc_rx_lanes = code_to_lanes(local_rx_max_i);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !reinit_i) |=> ($stable(tx_q) && $stable(rx_q) && $stable(gen_q)));
  p_gen_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && gen_q) |-> $past(peer_cap_valid_i));
  p_tx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_lanes <= $past(loc_tx_lanes)));
  p_rx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rx_lanes <= $past(loc_rx_lanes)));
  p_reinit_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (tx_q == 2'b00 && rx_q == 2'b00 && !link_q && !done_o));
endmodule

// File: tb/tb_lane_width_negotiator.sv
`timescale 1ns/1ps
module tb_lane_width_negotiator;
  localparam int LEG = 2000;
  localparam int TMO = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reinit = 1'b0;
  logic [1:0] loc_tx = 2'b10, loc_rx = 2'b10;
  logic cap_v = 1'b0, err_v = 1'b0;
  logic [1:0] p_tx = 2'b00, p_rx = 2'b00;
  logic [3:0] err_l = 4'b0;
  logic adv_v, done;
  logic [1:0] adv_tx, adv_rx, tx_w, rx_w;
  logic [31:0] stat;

  int checks = 0, fails = 0;

  typedef struct { logic [1:0] tx; logic [1:0] rx; logic gen; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  lane_width_negotiator dut (
    .clk_i(clk), .rst_ni(rst_n), .reinit_i(reinit),
    .local_tx_max_i(loc_tx), .local_rx_max_i(loc_rx),
    .adv_valid_o(adv_v), .adv_tx_code_o(adv_tx), .adv_rx_code_o(adv_rx),
    .peer_cap_valid_i(cap_v), .peer_tx_max_i(p_tx), .peer_rx_max_i(p_rx),
    .peer_err_valid_i(err_v), .peer_err_lanes_i(err_l),
    .tx_width_o(tx_w), .rx_width_o(rx_w), .neg_status_o(stat), .done_o(done)
  );

  function automatic int b_lanes(logic [1:0] c);
    if (c == 2'b00) return 1;
    if (c == 2'b01) return 2;
    if (c == 2'b11) return 3;
    return 4;
  endfunction
  function automatic logic [1:0] b_code(int n);
    if (n == 2) return 2'b01;
    if (n == 3) return 2'b11;
    if (n == 4) return 2'b10;
    return 2'b00;
  endfunction
  function automatic int b_min(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(int tx_n, int rx_n, logic gen, string req);
    exp_t e;
    e.tx = b_code(tx_n); e.rx = b_code(rx_n); e.gen = gen; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: compare each done against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(tx_w == e.tx, e.req, "tx width", tx_w, e.tx);
        chk(rx_w == e.rx, e.req, "rx width", rx_w, e.rx);
        chk(stat == {15'b0, e.gen, 15'b0, 1'b1}, "R11", "status", stat, {15'b0, e.gen, 15'b0, 1'b1});
      end
    end
  end

  task automatic wait_adv(int expn, string req);
    int n = 0;
    while (!adv_v && n < LEG + 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == expn, req, "legacy window length", n, expn);
    chk(adv_tx == loc_tx && adv_rx == loc_rx, "R2", "advertised codes", {adv_tx, adv_rx}, {loc_tx, loc_rx});
  endtask

  task automatic do_reinit();
    reinit = 1'b1;
    @(negedge clk);
    reinit = 1'b0;
    chk(tx_w == 2'b00 && rx_w == 2'b00, "R10", "widths after reinit", {tx_w, rx_w}, 0);
    chk(stat == 32'h0 && !done && !adv_v, "R10", "status after reinit", stat, 0);
  endtask

  task automatic after_done(string req);
    @(negedge clk);
    chk(done == 1'b1, req, "done fires", done, 1);
    cap_v = 1'b0; err_v = 1'b0; err_l = '0;
    @(negedge clk);
    chk(!done && !adv_v, "R8", "done one cycle, adv low", {done, adv_v}, 0);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] htx, hrx;
    logic [31:0] hst;
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(tx_w == 0 && rx_w == 0 && stat == 0 && !done && !adv_v, "R1", "reset state",
        {tx_w, rx_w, done, adv_v}, 0);
    rst_n = 1'b1;
    chk(tx_w == 0 && rx_w == 0 && stat == 0, "R1", "after release", {tx_w, rx_w}, 0);

    // case 1: capability reply, local tx 4 rx 3, peer tx 2 rx 4 (R3 code map)
    loc_tx = 2'b10; loc_rx = 2'b11;
    wait_adv(LEG, "R2");
    repeat (3) @(negedge clk);
    chk(adv_v && !done, "R4", "still advertising before reply", adv_v, 1);
    push(b_min(4, 4), b_min(3, 2), 1'b1, "R4");
    p_tx = 2'b01; p_rx = 2'b10; cap_v = 1'b1;
    after_done("R4");
    chk(tx_w == 2'b10 && rx_w == 2'b01, "R3", "code mapping 4 and 2 lanes", {tx_w, rx_w}, 4'b1001);

    // case 2: legacy peer, lanes 0111 -> 3; local tx 2 rx 4
    loc_tx = 2'b01; loc_rx = 2'b10;
    do_reinit();
    wait_adv(LEG, "R10");
    err_v = 1'b1; err_l = 4'b0000;
    repeat (4) @(negedge clk);
    chk(adv_v && !done, "R6", "empty error mask ignored", adv_v, 1);
    push(b_min(2, 3), b_min(4, 3), 1'b0, "R5");
    err_l = 4'b0111;
    after_done("R5");

    // case 3: capability and error same cycle, cap wins; peer tx 1 rx 3
    loc_tx = 2'b10; loc_rx = 2'b10;
    do_reinit();
    wait_adv(LEG, "R2");
    push(3, 1, 1'b1, "R6");
    p_tx = 2'b00; p_rx = 2'b11; cap_v = 1'b1; err_v = 1'b1; err_l = 4'b1111;
    after_done("R6");

    // case 4: silent peer -> timeout fallback
    do_reinit();
    wait_adv(LEG, "R2");
    push(1, 1, 1'b0, "R7");
    n = 0;
    while (!done && n < TMO + 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == TMO, "R7", "timeout length", n, TMO);
    @(negedge clk);
    chk(!done, "R8", "done drop after timeout", done, 0);

    // case 5: stray reply in legacy window, then error reply 1010 -> 2 lanes
    do_reinit();
    cap_v = 1'b1; p_tx = 2'b10; p_rx = 2'b10;
    n = 0;
    repeat (20) begin
      if (adv_v || done) n++;
      @(negedge clk);
    end
    cap_v = 1'b0;
    chk(n == 0, "R9", "reply in legacy window ignored", n, 0);
    wait_adv(LEG - 20, "R2");
    push(2, 2, 1'b0, "R5");
    err_v = 1'b1; err_l = 4'b1010;
    after_done("R5");

    // hold: replies after done have no effect
    htx = tx_w; hrx = rx_w; hst = stat;
    cap_v = 1'b1; p_tx = 2'b10; p_rx = 2'b10; err_v = 1'b1; err_l = 4'b1111;
    n = 0;
    repeat (10) begin
      @(negedge clk);
      if (tx_w != htx || rx_w != hrx || stat != hst || done || adv_v) n++;
    end
    cap_v = 1'b0; err_v = 1'b0; err_l = '0;
    chk(n == 0, "R9", "outputs held after done", n, 0);
    chk(tx_w == 2'b01 && rx_w == 2'b01, "R9", "held widths", {tx_w, rx_w}, 4'b0101);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all expected done strobes seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule